// File: doc/BRIEF.md
# Receive Character Queue with Special-Condition Hold

This block sits between the deframer of a serial receiver and the host bus. Each received character enters a short queue together with four per-character flags: parity error, overrun, framing or CRC error, and end of frame. The host or a DMA engine always sees the oldest queued character on `rd_data`. Its flags appear on `rd_stat`.

Ordinary characters drain through the DMA request. When the host reads a character that carries any flag, the block does not advance the queue. It raises a special-condition interrupt and holds that character at the exit, so a single status read describes the character already fetched. The receive side keeps filling the remaining free entries. An error-reset command releases the hold and discards the flagged character in the same cycle.

Top module: `rx_stat_fifo`

## Requirements
- R1: `rd_stat` shows the exit entry's flags at these positions: parity error on bit 4, overrun on bit 5, framing/CRC error on bit 6, end of frame on bit 7. Bits 3..0 are always 0. When the queue is empty, both `rd_data` and `rd_stat` read as 0.
- R2: A read (`rd_en`) of a flag-free exit entry removes it, and the next entry appears on the following cycle. `dma_req` is high whenever the queue holds a character and no hold is active.
- R3: A read of an exit entry that has any flag set raises `spec_irq` on the next cycle. The entry stays at the exit with its data and status unchanged. `spec_irq` never rises without a read in the cycle before.
- R4: While `spec_irq` is high, `dma_req` is low and further reads have no effect on the exit entry.
- R5: Writes (`wr_en`) are still stored in free entries while the hold is active.
- R6: `err_reset` during a hold clears `spec_irq` and removes the held entry in the same clock edge. If the next exit entry is also flagged, `spec_irq` rises again only once that entry is read.
- R7: `err_reset` while no hold is active has no effect.
- R8: A write while all DEPTH (default 3) entries are full, with no removal in that cycle, replaces the most recently written entry with the new character and sets its overrun flag.
- R9: A write in the same cycle as a removal from a full queue is stored normally, with no overrun flag.
- R10: A synchronous active-high `rst` empties the queue, clears all flags and releases the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receive side delivers a character |
| wr_data | input | 8 | Received character |
| wr_par_err | input | 1 | Parity error flag of the character |
| wr_frm_err | input | 1 | Framing or CRC error flag of the character |
| wr_eof | input | 1 | End-of-frame flag of the character |
| rd_en | input | 1 | Host or DMA reads the exit character |
| err_reset | input | 1 | Error-reset command |
| rd_data | output | 8 | Exit character |
| rd_stat | output | 8 | Status view of the exit character |
| dma_req | output | 1 | DMA may fetch the exit character |
| spec_irq | output | 1 | Special-condition interrupt request |

## Verification
The assertions assume that reads and error resets come from one agent and last one cycle each, and that `rst` is a clean synchronous pulse. The properties on a held entry rely on the exit character changing only through removal. The stimulus is applied on falling edges, holds every control for exactly one cycle, and issues `err_reset` both during a hold and outside one. It fills the queue to capacity before each overrun and each simultaneous read-plus-write case.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              eof;
        logic              frm;
        logic              ovr;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    function automatic logic has_special(input rx_entry_t e);
        return e.eof | e.frm | e.ovr | e.par;
    endfunction

    function automatic logic [7:0] status_view(input rx_entry_t e);
        return {e.eof, e.frm, e.ovr, e.par, 4'b0000};
    endfunction

endpackage

// File: rtl/rsf_store.sv
module rsf_store
    import rsf_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    rx_entry_t         slot_q [DEPTH];
    logic [PW-1:0]     rd_ptr_q, wr_ptr_q, newest;
    logic [CW-1:0]     count_q;
    logic              overwrite, append;
    logic [DEPTH-1:0]  slot_we;
    rx_entry_t         slot_wdata;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    assign newest    = ptr_dec(wr_ptr_q);
    assign overwrite = push && (count_q == FULL) && !pop;
    assign append    = push && !overwrite;
    assign empty     = (count_q == '0);

    always_comb begin
        slot_wdata = push_entry;
        if (overwrite) slot_wdata.ovr = 1'b1;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            assign slot_we[g] = (append    && wr_ptr_q == PW'(g)) ||
                                (overwrite && newest   == PW'(g));
            always_ff @(posedge clk) begin
                if (rst)             slot_q[g] <= '0;
                else if (slot_we[g]) slot_q[g] <= slot_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (pop)    rd_ptr_q <= ptr_inc(rd_ptr_q);
            if (append) wr_ptr_q <= ptr_inc(wr_ptr_q);
            case ({append, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head = empty ? '0 : slot_q[rd_ptr_q];

endmodule

// File: rtl/rsf_hold_ctrl.sv
module rsf_hold_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    input  logic err_reset,
    input  logic empty,
    input  logic head_special,
    output logic pop,
    output logic hold
);
    logic hold_q;
    logic read_ok;

    assign read_ok = rd_en && !empty && !hold_q;
    assign pop     = (read_ok && !head_special) || (err_reset && hold_q);

    always_ff @(posedge clk) begin
        if (rst)                          hold_q <= 1'b0;
        else if (err_reset)               hold_q <= 1'b0;
        else if (read_ok && head_special) hold_q <= 1'b1;
    end

    assign hold = hold_q;

endmodule

// File: rtl/rx_stat_fifo.sv
module rx_stat_fifo
    import rsf_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_par_err,
    input  logic              wr_frm_err,
    input  logic              wr_eof,
    input  logic              rd_en,
    input  logic              err_reset,
    output logic [CHAR_W-1:0] rd_data,
    output logic [7:0]        rd_stat,
    output logic              dma_req,
    output logic              spec_irq
);
    rx_entry_t in_entry, head;
    logic      empty, pop, hold;

    assign in_entry = '{eof: wr_eof, frm: wr_frm_err, ovr: 1'b0,
                        par: wr_par_err, data: wr_data};

    rsf_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (wr_en),
        .push_entry (in_entry),
        .pop        (pop),
        .head       (head),
        .empty      (empty)
    );

    rsf_hold_ctrl u_hold (
        .clk          (clk),
        .rst          (rst),
        .rd_en        (rd_en),
        .err_reset    (err_reset),
        .empty        (empty),
        .head_special (has_special(head)),
        .pop          (pop),
        .hold         (hold)
    );

    assign rd_data  = head.data;
    assign rd_stat  = status_view(head);
    assign dma_req  = !empty && !hold;
    assign spec_irq = hold;

endmodule

// File: rtl/rx_stat_fifo_checks.sv
module rx_stat_fifo_checks (
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic       err_reset,
    input logic [7:0] rd_data,
    input logic [7:0] rd_stat,
    input logic       dma_req,
    input logic       spec_irq
);
    AST_LOW_STAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_stat[3:0] == 4'h0); // R1
    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!dma_req && !spec_irq) |-> (rd_data == 8'h00 && rd_stat == 8'h00)); // R1
    AST_IRQ_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(spec_irq) |-> $past(rd_en)); // R3
    AST_HOLD_KEEPS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (spec_irq && !err_reset) |=> ($stable(rd_data) && $stable(rd_stat))); // R3
    AST_HOLD_BLOCKS_DMA: assert property (@(posedge clk) disable iff (rst)
        spec_irq |-> !dma_req); // R4
    AST_ERRST_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        err_reset |=> !spec_irq); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!spec_irq && !dma_req && rd_stat == 8'h00)); // R10
endmodule

bind rx_stat_fifo rx_stat_fifo_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .err_reset (err_reset),
    .rd_data   (rd_data),
    .rd_stat   (rd_stat),
    .dma_req   (dma_req),
    .spec_irq  (spec_irq)
);

// File: tb/rx_stat_fifo_tb_top.sv
module rx_stat_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_par_err = 1'b0, wr_frm_err = 1'b0, wr_eof = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0, err_reset = 1'b0;
    logic [7:0] rd_data, rd_stat;
    logic       dma_req, spec_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_stat_fifo dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .wr_eof(wr_eof),
        .rd_en(rd_en), .err_reset(err_reset), .rd_data(rd_data),
        .rd_stat(rd_stat), .dma_req(dma_req), .spec_irq(spec_irq)
    );

    // {wr, par, frm, eof, wdata, rd, erst, exp_data, exp_stat[7:4], exp_irq, exp_dma}
    // status nibble {eof, frm, ovr, par}
    localparam int NV = 18;
    localparam logic [27:0] VEC [NV] = '{
        {4'b1000, 8'h11, 2'b00, 8'h11, 4'h0, 2'b01}, // R2 first char visible
        {4'b1100, 8'h22, 2'b00, 8'h11, 4'h0, 2'b01}, // R2 parity char queued
        {4'b0000, 8'h00, 2'b10, 8'h22, 4'h1, 2'b01}, // R2 R1 clean pop, par bit4
        {4'b0000, 8'h00, 2'b10, 8'h22, 4'h1, 2'b10}, // R3 flagged read holds
        {4'b1001, 8'h33, 2'b10, 8'h22, 4'h1, 2'b10}, // R4 R5 read ignored, write kept
        {4'b0000, 8'h00, 2'b01, 8'h33, 4'h8, 2'b01}, // R6 release pops, eof bit7
        {4'b0000, 8'h00, 2'b10, 8'h33, 4'h8, 2'b10}, // R6 re-arms after read
        {4'b0000, 8'h00, 2'b01, 8'h00, 4'h0, 2'b00}, // R6 R1 empty reads zero
        {4'b0000, 8'h00, 2'b01, 8'h00, 4'h0, 2'b00}, // R7 idle error reset
        {4'b1010, 8'h44, 2'b00, 8'h44, 4'h4, 2'b01}, // R1 framing bit6
        {4'b1000, 8'h55, 2'b00, 8'h44, 4'h4, 2'b01}, // R8 fill
        {4'b1000, 8'h66, 2'b00, 8'h44, 4'h4, 2'b01}, // R8 full
        {4'b1000, 8'h77, 2'b00, 8'h44, 4'h4, 2'b01}, // R8 overrun write
        {4'b0000, 8'h00, 2'b10, 8'h44, 4'h4, 2'b10}, // R3 hold on framing
        {4'b0000, 8'h00, 2'b01, 8'h55, 4'h0, 2'b01}, // R6 release
        {4'b0000, 8'h00, 2'b10, 8'h77, 4'h2, 2'b01}, // R8 newest replaced, ovr bit5
        {4'b0000, 8'h00, 2'b10, 8'h77, 4'h2, 2'b10}, // R3 overrun holds
        {4'b0000, 8'h00, 2'b01, 8'h00, 4'h0, 2'b00}  // R6 drained
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic w, input logic p, input logic f, input logic e,
                        input logic [7:0] d, input logic r, input logic er);
        @(negedge clk);
        wr_en = w; wr_par_err = p; wr_frm_err = f; wr_eof = e; wr_data = d;
        rd_en = r; err_reset = er;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_par_err = 1'b0; wr_frm_err = 1'b0; wr_eof = 1'b0;
        rd_en = 1'b0; err_reset = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [7:0] d, input logic [7:0] s,
                              input logic irq, input logic dma);
        check({tag, " data"}, rd_data, d);
        check({tag, " stat"}, rd_stat, s);
        check({tag, " irq"},  {7'b0, spec_irq}, {7'b0, irq});
        check({tag, " dma"},  {7'b0, dma_req},  {7'b0, dma});
    endtask

    initial begin
        do_reset();
        expect_out("R10 R1 after reset", 8'h00, 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            step(v[27], v[26], v[25], v[24], v[23:16], v[15], v[14]);
            expect_out($sformatf("table row %0d (R1..R8 per row)", i),
                       v[13:6], {v[5:2], 4'h0}, v[1], v[0]);
        end

        // R9: read and write together on a full queue
        do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA2, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA3, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA4, 1'b1, 1'b0);
        expect_out("R9 pop with write", 8'hA2, 8'h00, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        expect_out("R9 second", 8'hA3, 8'h00, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        expect_out("R9 no overrun flag", 8'hA4, 8'h00, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        expect_out("R9 drained", 8'h00, 8'h00, 1'b0, 1'b0);

        // R10: reset while a hold is active
        step(1'b1, 1'b0, 1'b0, 1'b1, 8'hB1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        expect_out("R3 hold before reset", 8'hB1, 8'h80, 1'b1, 1'b0);
        do_reset();
        expect_out("R10 reset clears hold", 8'h00, 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule